// File: doc/BRIEF.md
# In-Order Multi-Issue Group Selector

This block sits between decode and the execution units of an in-order superscalar core. Each cycle it looks at a window of up to `WIDTH` decoded instructions, held oldest first in slot 0. It picks the longest run of instructions, starting at slot 0, that may begin execution together. The caller then moves the window forward by exactly the reported count.

Each instruction has two optional source register indices, an optional destination index and an operation class. The class is either a two-cycle multiply or a one-cycle simple ALU operation. The selector cuts the group at the first instruction that runs into any of three conditions:

- it reads a register that an older member of the same group writes;
- it reads a register whose multiply result is not yet forwardable;
- it would exceed the per-cycle unit budget for its class.

A write-ordering conflict also cuts the group. This is a younger writer whose result would land no later than that of an older writer of the same register. A small scoreboard keeps a countdown per architectural register so that results still in flight are tracked from cycle to cycle.

Register index 0 is an ordinary register with no hardwired value. Latencies, unit budgets, width and register count are parameters.

Top module: `issue_group_sel`

## Requirements
- R1: Coming out of reset the scoreboard is clear. A window of independent instructions within the unit budgets therefore issues at full width: one multiply and two ALU operations give a count of 3.
- R2: An instruction whose valid source equals the valid destination of an older instruction in the same group does not issue that cycle.
- R3: A result becomes readable `LAT` cycles after its producer issues. A dependent ALU consumer may issue in the cycle after an ALU producer (`ALU_LAT`=1). A consumer of a multiply result (`MUL_LAT`=2) is held in the cycle after the multiply issues and may issue the cycle after that.
- R4: Issue is strictly in order. When a slot is held, no younger slot issues that cycle, even one that has no hazard.
- R5: The unit budgets are set by `MUL_LIMIT` and `ALU_LIMIT`. A group holds at most `MUL_LIMIT` multiplies (`op_mul`=1) and at most `ALU_LIMIT` ALU operations (`op_mul`=0). The first instruction over its budget cuts the group. This holds both for the budget pair 1/2 and for the pair 1/1.
- R6: A younger writer of a register is held if its landing cycle, issue cycle plus its latency, is at or before that of an older writer of the same register. The older writer may be in the same group or still pending in the scoreboard. So an ALU write to a register in the cycle after a multiply to it is held, and two same-class writes to one register in one group cut at the younger. An ALU write followed by a multiply write in one group both issue.
- R7: A slot whose `win_valid` bit is low is empty. It and every younger slot do not issue.
- R8: A destination whose valid flag is low creates no hazard. A source whose valid flag is low never blocks.
- R9: Register index 0 is tracked like any other register. A read of register 0 after a same-group write to it is held.
- R10: `issue_count` lies in 0..`WIDTH`. `issue_mask` has bit i set exactly for slots i < `issue_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears the scoreboard |
| win_valid | input | WIDTH | Per-slot occupancy, slot 0 oldest |
| src0_idx | input | WIDTH x REG_W | First source register index per slot |
| src0_vld | input | WIDTH | First source in use |
| src1_idx | input | WIDTH x REG_W | Second source register index per slot |
| src1_vld | input | WIDTH | Second source in use |
| dst_idx | input | WIDTH x REG_W | Destination register index per slot |
| dst_vld | input | WIDTH | Destination in use |
| op_mul | input | WIDTH | Class per slot: 1 multiply, 0 simple ALU |
| issue_count | output | clog2(WIDTH+1) | Number of slots issued this cycle |
| issue_mask | output | WIDTH | Issued slots, contiguous from slot 0 |

## Verification
The two functions that can fall in the same cycle are the cut caused by the scoreboard and the cut caused by the same-group checks (source hazard, write ordering and unit budget). In-order truncation then decides which of them limits the count. Directed windows place a pending multiply destination beside a same-group hazard or a budget overflow in different slots. A constrained-random stream of small register indices makes both kinds of cut collide often. Each cycle's count and mask are compared against a bench model that keeps its own per-register countdown. The model is run for two unit budgets at once.

// File: rtl/issue_group_pkg.sv
// Package: shared helpers for the issue group selector.
// Assumes latencies are small positive integers.
package issue_group_pkg;

    // Pick the result latency of an instruction from its class bit.
    function automatic int lat_of(input logic is_mul, input int mul_lat, input int alu_lat);
        return is_mul ? mul_lat : alu_lat;
    endfunction

endpackage

// File: rtl/issue_scoreboard.sv
// Module: issue_scoreboard
// Keeps one countdown per architectural register. The count is the number of
// cycles left before the in-flight result is forwardable. Zero means readable.
// Reloaded on issue with latency-1 and decremented every cycle. When several
// issued slots write one register, the youngest wins (it lands latest).
// Assumes NREGS is a power of two so every index is in range.
module issue_scoreboard
    import issue_group_pkg::*;
#(
    parameter int W       = 3,
    parameter int NREGS   = 8,
    parameter int REG_W   = 3,
    parameter int CNT_W   = 2,
    parameter int MUL_LAT = 2,
    parameter int ALU_LAT = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [W-1:0]                  issue_mask,
    input  logic [W-1:0][REG_W-1:0]       dst_idx,
    input  logic [W-1:0]                  dst_vld,
    input  logic [W-1:0]                  op_mul,
    output logic [NREGS-1:0][CNT_W-1:0]   rem_q
);

    logic [NREGS-1:0][CNT_W-1:0] rem_nxt;

    // Next-state: count down, then reload for every issued writer in order.
    always_comb begin
        for (int r = 0; r < NREGS; r++) begin
            rem_nxt[r] = (rem_q[r] != '0) ? rem_q[r] - CNT_W'(1) : '0;
        end
        for (int s = 0; s < W; s++) begin
            if (issue_mask[s] && dst_vld[s]) begin
                rem_nxt[dst_idx[s]] = CNT_W'(lat_of(op_mul[s], MUL_LAT, ALU_LAT) - 1);
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_nxt;
    end

    // R3
    mul_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask[0] && dst_vld[0] && op_mul[0] && (MUL_LAT > 1))
        |=> (rem_q[$past(dst_idx[0])] != '0));

endmodule

// File: rtl/issue_slot_check.sv
// Module: issue_slot_check
// Decides whether the instruction in slot SLOT is blocked. It assumes every
// older slot issues, since the caller only uses this result when they do.
// Blocking causes: same-group source hazard, pending scoreboard source,
// write-ordering conflict against an older or pending writer, unit budget.
module issue_slot_check
    import issue_group_pkg::*;
#(
    parameter int W         = 3,
    parameter int SLOT      = 0,
    parameter int NREGS     = 8,
    parameter int REG_W     = 3,
    parameter int CNT_W     = 2,
    parameter int MUL_LIMIT = 1,
    parameter int ALU_LIMIT = 2,
    parameter int MUL_LAT   = 2,
    parameter int ALU_LAT   = 1
) (
    input  logic [REG_W-1:0]              own_src0,
    input  logic                          own_src0_vld,
    input  logic [REG_W-1:0]              own_src1,
    input  logic                          own_src1_vld,
    input  logic [REG_W-1:0]              own_dst,
    input  logic                          own_dst_vld,
    input  logic                          own_mul,
    input  logic [W-1:0][REG_W-1:0]       dst_idx,
    input  logic [W-1:0]                  dst_vld,
    input  logic [W-1:0]                  op_mul,
    input  logic [NREGS-1:0][CNT_W-1:0]   rem_q,
    output logic                          blocked
);

    logic raw_hit, pend_hit, waw_hit, cap_hit;
    int   my_lat, n_mul, n_alu;

    // Gather every hazard seen by this slot against older slots and the scoreboard.
    always_comb begin
        my_lat   = lat_of(own_mul, MUL_LAT, ALU_LAT);
        raw_hit  = 1'b0;
        waw_hit  = 1'b0;
        n_mul    = 0;
        n_alu    = 0;
        pend_hit = (own_src0_vld && rem_q[own_src0] != '0) ||
                   (own_src1_vld && rem_q[own_src1] != '0);
        if (own_dst_vld && int'(rem_q[own_dst]) >= my_lat) waw_hit = 1'b1;
        for (int j = 0; j < W; j++) begin
            if (j < SLOT && dst_vld[j]) begin
                if ((own_src0_vld && own_src0 == dst_idx[j]) ||
                    (own_src1_vld && own_src1 == dst_idx[j])) raw_hit = 1'b1;
                if (own_dst_vld && own_dst == dst_idx[j] &&
                    my_lat <= lat_of(op_mul[j], MUL_LAT, ALU_LAT)) waw_hit = 1'b1;
            end
            if (j <= SLOT) begin
                if (op_mul[j]) n_mul++;
                else           n_alu++;
            end
        end
        cap_hit = own_mul ? (n_mul > MUL_LIMIT) : (n_alu > ALU_LIMIT);
        blocked = raw_hit | pend_hit | waw_hit | cap_hit;
    end

endmodule

// File: rtl/issue_group_sel.sv
// Module: issue_group_sel (top)
// Picks the longest issuable prefix of the instruction window each cycle.
// Slot 0 is the oldest. The caller advances the window by issue_count.
// Assumes NREGS is a power of two and the latencies fit CNT_W.
module issue_group_sel #(
    parameter int WIDTH     = 3,
    parameter int NREGS     = 8,
    parameter int MUL_LIMIT = 1,
    parameter int ALU_LIMIT = 2,
    parameter int MUL_LAT   = 2,
    parameter int ALU_LAT   = 1,
    localparam int REG_W    = $clog2(NREGS),
    localparam int MAX_LAT  = (MUL_LAT > ALU_LAT) ? MUL_LAT : ALU_LAT,
    localparam int CNT_W    = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1,
    localparam int CNT_I    = $clog2(WIDTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WIDTH-1:0]                win_valid,
    input  logic [WIDTH-1:0][REG_W-1:0]     src0_idx,
    input  logic [WIDTH-1:0]                src0_vld,
    input  logic [WIDTH-1:0][REG_W-1:0]     src1_idx,
    input  logic [WIDTH-1:0]                src1_vld,
    input  logic [WIDTH-1:0][REG_W-1:0]     dst_idx,
    input  logic [WIDTH-1:0]                dst_vld,
    input  logic [WIDTH-1:0]                op_mul,
    output logic [CNT_I-1:0]                issue_count,
    output logic [WIDTH-1:0]                issue_mask
);

    logic [NREGS-1:0][CNT_W-1:0] rem_q;
    logic [WIDTH-1:0]            slot_blk;

    issue_scoreboard #(
        .W(WIDTH), .NREGS(NREGS), .REG_W(REG_W), .CNT_W(CNT_W),
        .MUL_LAT(MUL_LAT), .ALU_LAT(ALU_LAT)
    ) u_sb (
        .clk(clk), .rst_n(rst_n), .issue_mask(issue_mask),
        .dst_idx(dst_idx), .dst_vld(dst_vld), .op_mul(op_mul), .rem_q(rem_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        issue_slot_check #(
            .W(WIDTH), .SLOT(i), .NREGS(NREGS), .REG_W(REG_W), .CNT_W(CNT_W),
            .MUL_LIMIT(MUL_LIMIT), .ALU_LIMIT(ALU_LIMIT),
            .MUL_LAT(MUL_LAT), .ALU_LAT(ALU_LAT)
        ) u_chk (
            .own_src0(src0_idx[i]), .own_src0_vld(src0_vld[i]),
            .own_src1(src1_idx[i]), .own_src1_vld(src1_vld[i]),
            .own_dst(dst_idx[i]),   .own_dst_vld(dst_vld[i]),
            .own_mul(op_mul[i]),
            .dst_idx(dst_idx), .dst_vld(dst_vld), .op_mul(op_mul),
            .rem_q(rem_q), .blocked(slot_blk[i])
        );
    end

    // In-order prefix: a slot issues only if it and every older slot can.
    always_comb begin
        issue_count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (i == 0) issue_mask[i] = win_valid[i] & ~slot_blk[i];
            else        issue_mask[i] = issue_mask[i-1] & win_valid[i] & ~slot_blk[i];
            issue_count = issue_count + CNT_I'(issue_mask[i]);
        end
    end

    // R10
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_mask + WIDTH'(1)) & issue_mask) == '0);
    // R10
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(issue_mask) == int'(issue_count)) && (int'(issue_count) <= WIDTH));
    // R5
    mul_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_mask & op_mul) <= MUL_LIMIT);
    // R5
    alu_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_mask & ~op_mul) <= ALU_LIMIT);
    // R7
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask & ~win_valid) == '0);

endmodule

// File: tb/issue_group_sel_test.sv
`timescale 1ns/1ps
module issue_group_sel_test;
    localparam int W = 3, NREGS = 8, RW = 3, CI = 2;
    localparam int MUL_LAT = 2, ALU_LAT = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] win_valid, src0_vld, src1_vld, dst_vld, op_mul;
    logic [W-1:0][RW-1:0] src0_idx, src1_idx, dst_idx;
    logic [CI-1:0] cnt_w, cnt_n;
    logic [W-1:0]  mask_w, mask_n;
    int checks = 0, errors = 0;
    int rem_w [NREGS];
    int rem_n [NREGS];

    always #2 clk = ~clk;

    issue_group_sel #(.WIDTH(W), .NREGS(NREGS), .MUL_LIMIT(1), .ALU_LIMIT(2)) uut (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid),
        .src0_idx(src0_idx), .src0_vld(src0_vld), .src1_idx(src1_idx), .src1_vld(src1_vld),
        .dst_idx(dst_idx), .dst_vld(dst_vld), .op_mul(op_mul),
        .issue_count(cnt_w), .issue_mask(mask_w));

    issue_group_sel #(.WIDTH(W), .NREGS(NREGS), .MUL_LIMIT(1), .ALU_LIMIT(1)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid),
        .src0_idx(src0_idx), .src0_vld(src0_vld), .src1_idx(src1_idx), .src1_vld(src1_vld),
        .dst_idx(dst_idx), .dst_vld(dst_vld), .op_mul(op_mul),
        .issue_count(cnt_n), .issue_mask(mask_n));

    function automatic int lat(input logic m);
        return m ? MUL_LAT : ALU_LAT;
    endfunction

    // Bench model of the longest issuable prefix, from the requirements.
    function automatic int model_count(input int mul_lim, input int alu_lim, input int rem [NREGS]);
        int nm = 0, na = 0, c = 0;
        for (int i = 0; i < W; i++) begin
            bit blk = 0;
            if (!win_valid[i]) break;
            if (src0_vld[i] && rem[src0_idx[i]] > 0) blk = 1;
            if (src1_vld[i] && rem[src1_idx[i]] > 0) blk = 1;
            if (dst_vld[i] && rem[dst_idx[i]] >= lat(op_mul[i])) blk = 1;
            for (int j = 0; j < i; j++) begin
                if (dst_vld[j] && src0_vld[i] && src0_idx[i] == dst_idx[j]) blk = 1;
                if (dst_vld[j] && src1_vld[i] && src1_idx[i] == dst_idx[j]) blk = 1;
                if (dst_vld[j] && dst_vld[i] && dst_idx[i] == dst_idx[j] &&
                    lat(op_mul[i]) <= lat(op_mul[j])) blk = 1;
            end
            if (op_mul[i]) nm++; else na++;
            if (nm > mul_lim || na > alu_lim) blk = 1;
            if (blk) break;
            c++;
        end
        return c;
    endfunction

    task automatic model_step(inout int rem [NREGS], input int c);
        for (int r = 0; r < NREGS; r++) if (rem[r] > 0) rem[r]--;
        for (int s = 0; s < c; s++) if (dst_vld[s]) rem[dst_idx[s]] = lat(op_mul[s]) - 1;
    endtask

    task automatic cmp(input string tag, input int act_c, input int act_m, input int exp_c);
        int exp_m = (1 << exp_c) - 1;
        checks++;
        if (act_c != exp_c || act_m != exp_m) begin
            errors++;
            $display("FAIL %s: count %0d mask %b, expected count %0d mask %b",
                     tag, act_c, act_m[W-1:0], exp_c, exp_m[W-1:0]);
        end
    endtask

    // Inputs are already driven at a falling edge; check, update models, move on.
    task automatic step(input string tag, input int exp_wide, input int exp_narrow);
        int mw, mn;
        #1;
        mw = model_count(1, 2, rem_w);
        mn = model_count(1, 1, rem_n);
        if (exp_wide >= 0) begin
            cmp({tag, " wide"},   int'(cnt_w), int'(mask_w), exp_wide);
            cmp({tag, " narrow"}, int'(cnt_n), int'(mask_n), exp_narrow);
        end else begin
            cmp({tag, " wide"},   int'(cnt_w), int'(mask_w), mw);
            cmp({tag, " narrow"}, int'(cnt_n), int'(mask_n), mn);
        end
        model_step(rem_w, mw);
        model_step(rem_n, mn);
        @(negedge clk);
    endtask

    task automatic clr;
        win_valid = '0; src0_vld = '0; src1_vld = '0; dst_vld = '0; op_mul = '0;
        src0_idx = '0; src1_idx = '0; dst_idx = '0;
    endtask

    task automatic put(input int i, input int m, input int s0, input int s1, input int d);
        win_valid[i] = 1'b1; op_mul[i] = m[0];
        src0_idx[i] = RW'(s0); src0_vld[i] = 1'b1;
        src1_idx[i] = RW'(s1); src1_vld[i] = 1'b1;
        dst_idx[i] = RW'(d);   dst_vld[i] = 1'b1;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int r = 0; r < NREGS; r++) begin rem_w[r] = 0; rem_n[r] = 0; end
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 empty window", 0, 0);
        clr(); put(0,1,2,3,1); put(1,0,5,6,4); put(2,0,2,5,7);
        step("R1 full group", 3, 2);
        clr(); put(0,0,1,1,2);
        step("R3 mul consumer held", 0, 0);
        step("R3 mul consumer later", 1, 1);
        clr(); put(0,0,4,4,3); put(1,0,3,3,5);
        step("R2 same-group read", 1, 1);
        clr(); put(0,0,3,3,5);
        step("R3 alu forward next cycle", 1, 1);
        clr(); put(0,0,1,1,2); put(1,0,4,2,3); put(2,1,7,7,6);
        step("R4 younger held", 1, 1);
        clr(); put(0,1,4,5,1); put(1,1,6,7,2); put(2,1,4,6,3);
        step("R5 mul budget", 1, 1);
        clr(); put(0,0,5,6,1);
        step("R6 pending writer", 0, 0);
        step("R6 pending writer done", 1, 1);
        clr(); put(0,0,5,5,2); put(1,0,6,6,3); put(2,0,7,7,4);
        step("R5 alu budget", 2, 1);
        clr(); put(0,1,6,6,5); put(1,0,7,7,5);
        step("R6 alu after mul same reg", 1, 1);
        clr(); put(0,0,6,6,3); put(1,1,7,7,3);
        step("R6 mul after alu same reg", 2, 2);
        clr(); put(0,0,6,7,4); put(1,0,6,7,4);
        step("R6 equal landing", 1, 1);
        clr(); put(0,0,5,5,2); put(2,0,6,6,6);
        step("R7 gap in window", 1, 1);
        clr();
        step("R7 empty", 0, 0);
        clr(); put(0,0,5,5,3); dst_vld[0] = 1'b0; put(1,0,3,3,4);
        step("R8 no destination", 2, 1);
        clr(); put(0,1,5,5,6); put(1,0,6,2,7); src0_vld[1] = 1'b0;
        step("R8 unused source", 2, 2);
        clr(); put(0,0,5,5,0); put(1,0,0,5,4);
        step("R9 register zero", 1, 1);
        for (int n = 0; n < 4000; n++) begin
            clr();
            for (int i = 0; i < W; i++) begin
                win_valid[i] = ($urandom % 8) != 0;
                op_mul[i]    = ($urandom % 3) == 0;
                src0_idx[i]  = RW'($urandom); src0_vld[i] = ($urandom % 4) != 0;
                src1_idx[i]  = RW'($urandom); src1_vld[i] = ($urandom % 2) != 0;
                dst_idx[i]   = RW'($urandom); dst_vld[i]  = ($urandom % 6) != 0;
            end
            step("R2 R3 R4 R5 R6 R7 R8 R10 random", -1, -1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule